// File: doc/BRIEF.md
# Keyed Configuration-Space Unlock Controller

This block is the configuration space of a legacy I/O companion device. The host reaches it through two byte-wide ports, an index port at a base address and a data port one address above it. The space starts out locked. Until the host writes a four-byte key to the index port, configuration accesses do nothing. The key is 0x87, 0x01, 0x55, and then a final byte that depends on the base: 0x55 for base 0x2E and 0xAA for base 0x4E.

Once the space is open, the host writes a register number to the index port and then reads or writes that register through the data port. The space holds these registers:

- Two read-only identifier bytes.
- A flash-decode control register, whose bits drive the block's flash-control outputs.
- A logical-device selector.
- A bank of per-device registers holding each device's 16-bit I/O base.

Writing 0x02 to register 0x02 closes the space again.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: The space opens (`cfg_open` goes to 1 after the clock edge of the write) only when the last four index-port writes made while locked are 0x87, 0x01, 0x55 and a final byte. That final byte is 0x55 when `BASE_ADDR` is 0x2E and 0xAA when it is 0x4E. For base 0x2E, the sequence 0x87, 0x01, 0x55, 0xAA does not open it.
- R2: A key byte that does not match sends the key matcher back to its first step. A mismatching byte equal to 0x87 counts as the first key byte, so the next expected byte is 0x01.
- R3: While locked, reads of the index or data port return 0xFF, and data-port writes change no register and no output.
- R4: When the space is open, register 0x20 reads the high identifier byte and register 0x21 reads the low byte (defaults 0x87 and 0x16).
- R5: Register 0x07 holds the selected logical device. Registers 0x64 (high byte) and 0x65 (low byte) read and write the I/O base of the selected device. Each device keeps its own value. Device 7 resets to 0x0820 and the others reset to 0x0000.
- R6: Register 0x24 stores only bits 5..1 and reads 0 in bits 7, 6 and 0. Bits 3..1 drive `flash_seg_en[2:0]`, bit 4 drives `flash_wr_en` and bit 5 drives `flash_cs_sel`.
- R7: Writing 0x02 to register 0x02 locks the space and clears the index. Any other value written there leaves the space open. After a relock, the full key is needed again.
- R8: A synchronous active-high reset leaves the space locked, with the index at 0, logical device 0 selected and register 0x24 at 0.
- R9: Accesses to addresses other than the two ports change no state. Reads at such addresses return 0x00, and `io_rdata` is 0x00 whenever `io_rd` is low.
- R10: When the space is open, reading the index port returns the current index, and any register not listed above reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe; the write takes effect at the rising edge |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational from `io_addr` and state |
| cfg_open | output | 1 | Configuration space unlocked |
| flash_seg_en | output | 3 | Flash segment decode enables |
| flash_wr_en | output | 1 | Flash write enable |
| flash_cs_sel | output | 1 | Flash chip-select pin choice |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle, and that the address and data are steady for the whole cycle a strobe is high. The stability checks on locked and foreign writes rely on that cycle carrying only the one write. The bench drives each access on its own, starting at a falling edge and ending after the next rising edge, so no two strobes overlap. The bench also steers the key matcher through partial, broken and wrong-base sequences before each real unlock.

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl #(
  parameter logic [15:0] BASE_ADDR    = 16'h002E,
  parameter logic [15:0] CHIP_ID      = 16'h8716,
  parameter int          NUM_LDN      = 8,
  parameter int          FLASH_LDN    = 7,
  parameter logic [15:0] FLASH_IO_RST = 16'h0820
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        io_wr,
  input  logic        io_rd,
  output logic [7:0]  io_rdata,
  output logic        cfg_open,
  output logic [2:0]  flash_seg_en,
  output logic        flash_wr_en,
  output logic        flash_cs_sel
);
  localparam int         LDN_W   = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;
  localparam logic [7:0] KEY_END = (BASE_ADDR == 16'h004E) ? 8'hAA : 8'h55;
  localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;

  logic [1:0]       kstep;
  logic             open_q;
  logic [7:0]       idx_q;
  logic [LDN_W-1:0] ldn_q;
  logic [4:0]       fdec_q;
  logic [7:0]       base_hi [NUM_LDN];
  logic [7:0]       base_lo [NUM_LDN];
  logic [7:0]       key_exp;
  logic [7:0]       reg_rd;

  wire idx_hit = (io_addr == BASE_ADDR);
  wire dat_hit = (io_addr == DATA_ADDR);
  wire key_wr  = io_wr && idx_hit && !open_q;
  wire cfg_wr  = io_wr && dat_hit && open_q;
  wire ldn_ok  = (32'(ldn_q) < NUM_LDN);

  always_comb begin
    case (kstep)
      2'd0:    key_exp = 8'h87;
      2'd1:    key_exp = 8'h01;
      2'd2:    key_exp = 8'h55;
      default: key_exp = KEY_END;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kstep  <= 2'd0;
      open_q <= 1'b0;
      idx_q  <= 8'h00;
      ldn_q  <= '0;
      fdec_q <= 5'd0;
      for (int i = 0; i < NUM_LDN; i++) begin
        base_hi[i] <= (i == FLASH_LDN) ? FLASH_IO_RST[15:8] : 8'h00;
        base_lo[i] <= (i == FLASH_LDN) ? FLASH_IO_RST[7:0]  : 8'h00;
      end
    end else begin
      if (key_wr) begin
        if (io_wdata == key_exp) begin
          if (kstep == 2'd3) begin
            open_q <= 1'b1;
            kstep  <= 2'd0;
          end else begin
            kstep <= kstep + 2'd1;
          end
        end else begin
          kstep <= (io_wdata == 8'h87) ? 2'd1 : 2'd0;
        end
      end
      if (io_wr && idx_hit && open_q)
        idx_q <= io_wdata;
      if (cfg_wr) begin
        case (idx_q)
          8'h02: if (io_wdata == 8'h02) begin
                   open_q <= 1'b0;
                   idx_q  <= 8'h00;
                 end
          8'h07: ldn_q  <= io_wdata[LDN_W-1:0];
          8'h24: fdec_q <= io_wdata[5:1];
          8'h64: if (ldn_ok) base_hi[ldn_q] <= io_wdata;
          8'h65: if (ldn_ok) base_lo[ldn_q] <= io_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx_q)
      8'h07:   reg_rd = 8'(ldn_q);
      8'h20:   reg_rd = CHIP_ID[15:8];
      8'h21:   reg_rd = CHIP_ID[7:0];
      8'h24:   reg_rd = {2'b00, fdec_q, 1'b0};
      8'h64:   reg_rd = ldn_ok ? base_hi[ldn_q] : 8'h00;
      8'h65:   reg_rd = ldn_ok ? base_lo[ldn_q] : 8'h00;
      default: reg_rd = 8'h00;
    endcase
  end

  assign io_rdata = !io_rd                   ? 8'h00 :
                    !(idx_hit || dat_hit)    ? 8'h00 :
                    !open_q                  ? 8'hFF :
                    idx_hit                  ? idx_q : reg_rd;

  assign cfg_open     = open_q;
  assign flash_seg_en = fdec_q[2:0];
  assign flash_wr_en  = fdec_q[3];
  assign flash_cs_sel = fdec_q[4];
endmodule

// File: rtl/cfg_unlock_ctrl_chk.sv
module cfg_unlock_ctrl_chk #(
  parameter logic [15:0] BASE_ADDR = 16'h002E,
  parameter logic [15:0] CHIP_ID   = 16'h8716
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] io_addr,
  input logic [7:0]  io_wdata,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_rdata,
  input logic        cfg_open,
  input logic [2:0]  flash_seg_en,
  input logic        flash_wr_en,
  input logic        flash_cs_sel,
  input logic [7:0]  idx_q
);
  localparam logic [7:0]  KEY_END   = (BASE_ADDR == 16'h004E) ? 8'hAA : 8'h55;
  localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;

  wire [4:0] flash_vec = {flash_cs_sel, flash_wr_en, flash_seg_en};
  wire       foreign   = (io_addr != BASE_ADDR) && (io_addr != DATA_ADDR);

  p_open_on_key_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(io_wr && io_addr == BASE_ADDR && io_wdata == KEY_END));

  p_locked_read_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && io_rd && io_addr == DATA_ADDR) |-> io_rdata == 8'hFF);

  p_locked_write_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && io_wr && io_addr == DATA_ADDR) |=> ($stable(flash_vec) && !cfg_open));

  p_id_high_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && io_rd && io_addr == DATA_ADDR && idx_q == 8'h20) |-> io_rdata == CHIP_ID[15:8]);

  p_exit_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && io_wr && io_addr == DATA_ADDR && idx_q == 8'h02 && io_wdata == 8'h02) |=> !cfg_open);

  p_foreign_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (io_wr && foreign) |=> ($stable(cfg_open) && $stable(flash_vec)));

  p_idle_rdata_r9: assert property (@(posedge clk) disable iff (rst)
    !io_rd |-> io_rdata == 8'h00);
endmodule

bind cfg_unlock_ctrl cfg_unlock_ctrl_chk #(.BASE_ADDR(BASE_ADDR), .CHIP_ID(CHIP_ID)) chk_i (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
  .io_rd(io_rd), .io_rdata(io_rdata), .cfg_open(cfg_open), .flash_seg_en(flash_seg_en),
  .flash_wr_en(flash_wr_en), .flash_cs_sel(flash_cs_sel), .idx_q(idx_q)
);

// File: tb/cfg_unlock_ctrl_tb_top.sv
`timescale 1ns/100ps
module cfg_unlock_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        cfg_open;
  logic [2:0]  flash_seg_en;
  logic        flash_wr_en;
  logic        flash_cs_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model state
  byte unsigned key_q[$] = '{8'h87, 8'h01, 8'h55, 8'h55};
  int           m_step;
  bit           m_open;
  int           m_idx, m_ldn, m_fdec;
  int           m_hi[8], m_lo[8];

  always #2.5 clk = ~clk;

  cfg_unlock_ctrl dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
    .io_rd(io_rd), .io_rdata(io_rdata), .cfg_open(cfg_open), .flash_seg_en(flash_seg_en),
    .flash_wr_en(flash_wr_en), .flash_cs_sel(flash_cs_sel)
  );

  task automatic chk(string tag, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_step = 0; m_open = 0; m_idx = 0; m_ldn = 0; m_fdec = 0;
    for (int i = 0; i < 8; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
    m_hi[7] = 8'h08; m_lo[7] = 8'h20;
  endtask

  task automatic m_write(int a, int d);
    if (a == 16'h2E && !m_open) begin
      if (d == key_q[m_step]) begin
        if (m_step == 3) begin m_open = 1; m_step = 0; end
        else m_step++;
      end else m_step = (d == 8'h87) ? 1 : 0;
    end else if (a == 16'h2E) m_idx = d;
    else if (a == 16'h2F && m_open) begin
      if (m_idx == 8'h02 && d == 8'h02) begin m_open = 0; m_idx = 0; end
      else if (m_idx == 8'h07) m_ldn = d % 8;
      else if (m_idx == 8'h24) m_fdec = d & 8'h3E;
      else if (m_idx == 8'h64) m_hi[m_ldn] = d;
      else if (m_idx == 8'h65) m_lo[m_ldn] = d;
    end
  endtask

  function automatic int m_read(int a);
    if (a != 16'h2E && a != 16'h2F) return 0;
    if (!m_open) return 8'hFF;
    if (a == 16'h2E) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'h87;
      8'h21: return 8'h16;
      8'h24: return m_fdec;
      8'h64: return m_hi[m_ldn];
      8'h65: return m_lo[m_ldn];
      default: return 0;
    endcase
  endfunction

  // per-clock comparison of the steady outputs (R1 open flag, R6 flash outputs)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 cfg_open", int'(cfg_open), int'(m_open));
      chk("R6 flash outputs", int'({flash_cs_sel, flash_wr_en, flash_seg_en}), (m_fdec >> 1) & 8'h1F);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1'b1;
    @(posedge clk);
    #1;
    m_write(a, d);
    io_wr = 1'b0;
  endtask

  task automatic rd(string tag, int a);
    @(negedge clk);
    io_addr = 16'(a); io_rd = 1'b1;
    #1;
    chk(tag, int'(io_rdata), m_read(a));
    @(posedge clk);
    #1;
    io_rd = 1'b0;
  endtask

  task automatic reg_rd(string tag, int r);
    wr(16'h2E, r);
    rd(tag, 16'h2F);
  endtask

  task automatic reg_wr(int r, int d);
    wr(16'h2E, r);
    wr(16'h2F, d);
  endtask

  task automatic unlock();
    foreach (key_q[i]) wr(16'h2E, key_q[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    m_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;

    // R8 reset state, R3 locked reads
    chk("R8 locked after reset", int'(cfg_open), 0);
    chk("R8 flash reg cleared", int'({flash_cs_sel, flash_wr_en, flash_seg_en}), 0);
    rd("R3 locked data read", 16'h2F);
    rd("R3 locked index read", 16'h2E);
    rd("R9 idle read elsewhere", 16'h0080);
    wr(16'h2F, 8'hFF);
    wr(16'h2F, 8'h3E);

    // R1 unlock
    unlock();
    chk("R1 open after key", int'(cfg_open), 1);
    rd("R8 index cleared", 16'h2E);
    reg_rd("R3 locked writes left 0x24 unchanged", 8'h24);
    reg_rd("R8 ldn zero", 8'h07);

    // R4 identifier
    reg_rd("R4 id high", 8'h20);
    reg_rd("R4 id low", 8'h21);
    reg_rd("R10 unused reg", 8'h55);
    rd("R10 index readback", 16'h2E);

    // R6 flash decode
    reg_wr(8'h24, 8'hFF);
    reg_rd("R6 masked 0x24", 8'h24);
    chk("R6 all outputs high", int'({flash_cs_sel, flash_wr_en, flash_seg_en}), 5'h1F);
    reg_wr(8'h24, 8'h0A);
    reg_rd("R6 0x24 pattern", 8'h24);
    chk("R6 seg enables", int'(flash_seg_en), 3'b101);
    reg_wr(8'h24, 8'h30);
    chk("R6 wr and cs", int'({flash_cs_sel, flash_wr_en, flash_seg_en}), 5'b11000);

    // R5 logical devices
    reg_wr(8'h07, 8'h07);
    reg_rd("R5 ldn7 base high", 8'h64);
    reg_rd("R5 ldn7 base low", 8'h65);
    reg_wr(8'h64, 8'h12);
    reg_wr(8'h65, 8'h34);
    reg_rd("R5 ldn7 new high", 8'h64);
    reg_wr(8'h07, 8'h03);
    reg_rd("R5 ldn3 base high", 8'h64);
    reg_wr(8'h64, 8'hAB);
    reg_rd("R5 ldn3 written", 8'h64);
    reg_wr(8'h07, 8'h07);
    reg_rd("R5 ldn7 kept", 8'h64);
    reg_rd("R5 ldn7 low kept", 8'h65);

    // R9 foreign addresses
    wr(16'h004E, 8'h24);
    wr(16'h004F, 8'h00);
    wr(16'h0030, 8'h02);
    rd("R9 foreign read", 16'h004F);
    rd("R9 index unchanged", 16'h2E);

    // R7 exit
    reg_wr(8'h02, 8'h01);
    chk("R7 wrong exit value", int'(cfg_open), 1);
    reg_wr(8'h02, 8'h02);
    chk("R7 locked after exit", int'(cfg_open), 0);
    rd("R3 locked after exit", 16'h2F);

    // R2 broken sequences
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h12);
    wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
    chk("R2 broken key stays locked", int'(cfg_open), 0);
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h87); wr(16'h2E, 8'h01);
    wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
    chk("R2 0x87 restarts at step two", int'(cfg_open), 1);
    rd("R7 index cleared on relock", 16'h2E);
    reg_wr(8'h02, 8'h02);

    // R1 wrong-base final byte
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h55); wr(16'h2E, 8'hAA);
    chk("R1 wrong final byte", int'(cfg_open), 0);
    unlock();
    chk("R1 reopen", int'(cfg_open), 1);

    // R8 reset while open
    reg_wr(8'h24, 8'h3E);
    reg_wr(8'h07, 8'h05);
    do_reset();
    chk("R8 reset locks", int'(cfg_open), 0);
    chk("R8 reset flash", int'({flash_cs_sel, flash_wr_en, flash_seg_en}), 0);
    unlock();
    rd("R8 index after reset", 16'h2E);
    reg_rd("R8 ldn after reset", 8'h07);
    reg_rd("R5 ldn0 base after reset", 8'h64);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule